// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block sits beside the data port of a NAND flash bus controller and builds a 3-byte single-error-correcting parity code over each 256-byte chunk that crosses the port, whether the host is writing bytes toward the flash or reading them back. Software selects its behaviour through a 2-bit mode field held in the controller's mode register. The same block serves both page programming, where the code is stored in the spare area, and page reads, where software compares the fresh code with the stored one and corrects the data itself.

A chunk begins with the host writing the clear code, then idle, then accumulate. Every completed byte transfer then folds into 16 line-parity bits, chosen by the byte's position in the chunk, and 6 column-parity bits, chosen by bit position within the byte. Afterwards the host selects read-out and fetches the code with three consecutive data-port reads. These return the middle byte first, then the low byte, then the high byte. The accumulator then holds its value until the next clear.

The mode field is a state machine with four states: `MODE_IDLE` (00), `MODE_ACCUM` (01), `MODE_SHOW` (10) and `MODE_CLEAR` (11). A write to the field moves it from any state to the written state. A second machine steps the read-out byte through `SEQ_MID` → `SEQ_LOW` → `SEQ_HIGH` → `SEQ_MID`, one step per read strobe while in `MODE_SHOW`. Any write to the mode field returns it to `SEQ_MID`.

Top module: `nand_ecc_gen`

## Requirements
- R1: After reset the mode is idle, `ecc_show` is 0, `ecc_out` is 0, and the parity accumulator and byte index are cleared, so an immediate read-out returns FF, FF, FF.
- R2: A `mode_wr` pulse loads `mode_in` into the mode field, and the new mode is in effect from the next clock. Code 11 clears the accumulator and the byte index on every cycle it is held, 01 accumulates, 10 reads out, and 00 idles.
- R3: In accumulate mode, each cycle with `xfer_valid` high folds `xfer_data` into the parities at the current byte index, then advances the index. The index starts at 0 after a clear and wraps from 255 to 0.
- R4: In idle and read-out modes, data transfers leave the accumulator and the byte index unchanged.
- R5: The code stores every parity bit inverted. Line parity bit 2k is the XOR of the byte parities of all bytes whose index bit k is 0, and bit 2k+1 covers the bytes whose index bit k is 1, for k = 0..7. Column parity bit 2j is the XOR over all bytes of the data bits whose position has bit j clear, and bit 2j+1 covers the positions with bit j set, for j = 0..2. The bytes are: byte0 = ~line[7:0], byte1 = ~line[15:8], byte2 = {~col[5:0], 2'b11}. A chunk of all-FF data gives FF, FF, FF.
- R6: In read-out mode `ecc_out` presents byte1. Each `rd_strobe` steps to the next byte in the order byte1, byte0, byte2, and the step after byte2 returns to byte1.
- R7: Any `mode_wr` returns the read-out sequencer to byte1, and it takes priority over a `rd_strobe` in the same cycle.
- R8: `ecc_show` is 1 exactly while the mode is read-out. In every other mode `ecc_out` is 0.
- R9: Leaving read-out for idle and later returning to read-out yields the same three code bytes, as long as no clear code has been written in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_in | input | 2 | New mode field value (00 idle, 01 accumulate, 10 read-out, 11 clear) |
| xfer_valid | input | 1 | One data byte transfer completes this cycle |
| xfer_data | input | 8 | Byte being transferred |
| rd_strobe | input | 1 | Data-port read of a code byte completes this cycle |
| ecc_show | output | 1 | High while the mode is read-out |
| ecc_out | output | 8 | Code byte selected by the read-out sequencer |

## Verification
On every cycle, the assertions check these properties:
- A clear cycle leaves both parity vectors at zero.
- Parities and the byte index hold whenever no accumulating transfer occurs.
- The index advances by exactly one per accumulating transfer.
- A mode write always restarts the sequencer at the middle byte.
- The sequencer wraps from the high byte to the middle byte.

Only the bench's scenarios can show that the parity values themselves are correct. Those scenarios cover random and erased chunks, chunks shorter and longer than 256 bytes, and the delivered byte order. They also show that transfers made in idle or read-out mode leave the code unchanged when it is read again.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    localparam int BYTE_W      = 8;
    localparam int CHUNK_BYTES = 256;
    localparam int IDX_W       = $clog2(CHUNK_BYTES);
    localparam int LP_W        = 2 * IDX_W;
    localparam int CP_W        = 2 * $clog2(BYTE_W);

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ACCUM = 2'b01,
        MODE_SHOW  = 2'b10,
        MODE_CLEAR = 2'b11
    } ecc_mode_e;

    typedef enum logic [1:0] {
        SEQ_MID  = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2
    } seq_e;

endpackage

// File: rtl/ecc_ctrl_fsm.sv
module ecc_ctrl_fsm
    import nand_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_in,
    input  logic       rd_strobe,
    output ecc_mode_e  mode_q,
    output seq_e       seq_q
);

    ecc_mode_e mode_d;
    seq_e      seq_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE;
            seq_q  <= SEQ_MID;
        end else begin
            mode_q <= mode_d;
            seq_q  <= seq_d;
        end
    end

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        seq_d  = seq_q;
        if (mode_wr) begin
            mode_d = ecc_mode_e'(mode_in);
            seq_d  = SEQ_MID;
        end else if (mode_q == MODE_SHOW && rd_strobe) begin
            unique case (seq_q)
                SEQ_MID:  seq_d = SEQ_LOW;
                SEQ_LOW:  seq_d = SEQ_HIGH;
                SEQ_HIGH: seq_d = SEQ_MID;
                default:  seq_d = SEQ_MID;
            endcase
        end
    end

    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> seq_q == SEQ_MID); // R7

    AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr && mode_q == MODE_SHOW && rd_strobe && seq_q == SEQ_HIGH)
        |=> seq_q == SEQ_MID); // R6

    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr && mode_q != MODE_SHOW) |=> $stable(seq_q)); // R6

    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> mode_q == $past(mode_in)); // R2

endmodule

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc
    import nand_ecc_pkg::*;
#(
    parameter int DW   = BYTE_W,
    parameter int IW   = IDX_W,
    localparam int LW  = 2 * IW,
    localparam int CW  = 2 * $clog2(DW),
    localparam int PBW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          enable,
    input  logic          xfer_valid,
    input  logic [DW-1:0] xfer_data,
    output logic [LW-1:0] line_par,
    output logic [CW-1:0] col_par
);

    logic [IW-1:0] idx_q;
    logic [LW-1:0] line_flip;
    logic [CW-1:0] col_flip;
    logic          byte_par;

    assign byte_par = ^xfer_data;

    // line parity: one pair per index bit
    for (genvar k = 0; k < IW; k++) begin : g_line
        assign line_flip[2*k]   = byte_par & ~idx_q[k];
        assign line_flip[2*k+1] = byte_par &  idx_q[k];
    end

    // column parity: one pair per bit-position bit
    for (genvar j = 0; j < PBW; j++) begin : g_col
        logic [DW-1:0] lo_mask;
        for (genvar b = 0; b < DW; b++) begin : g_mask
            assign lo_mask[b] = ((b >> j) & 1) == 0;
        end
        assign col_flip[2*j]   = ^(xfer_data &  lo_mask);
        assign col_flip[2*j+1] = ^(xfer_data & ~lo_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            line_par <= '0;
            col_par  <= '0;
        end else if (clear) begin
            idx_q    <= '0;
            line_par <= '0;
            col_par  <= '0;
        end else if (enable && xfer_valid) begin
            idx_q    <= idx_q + 1'b1;
            line_par <= line_par ^ line_flip;
            col_par  <= col_par ^ col_flip;
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (line_par == '0 && col_par == '0 && idx_q == '0)); // R2

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(enable && xfer_valid))
        |=> ($stable(line_par) && $stable(col_par) && $stable(idx_q))); // R4

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && enable && xfer_valid)
        |=> idx_q == $past(idx_q) + 1'b1); // R3

endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
    import nand_ecc_pkg::*;
#(
    parameter int DW  = BYTE_W,
    parameter int LW  = LP_W,
    parameter int CW  = CP_W
) (
    input  logic          show,
    input  seq_e          seq,
    input  logic [LW-1:0] line_par,
    input  logic [CW-1:0] col_par,
    output logic [DW-1:0] ecc_out
);

    localparam int PADW = DW - CW;

    logic [DW-1:0] code_lo, code_mid, code_hi;

    assign code_lo  = ~line_par[DW-1:0];
    assign code_mid = ~line_par[2*DW-1:DW];
    assign code_hi  = {~col_par, {PADW{1'b1}}};

    always_comb begin
        ecc_out = '0;
        if (show) begin
            unique case (seq)
                SEQ_MID:  ecc_out = code_mid;
                SEQ_LOW:  ecc_out = code_lo;
                SEQ_HIGH: ecc_out = code_hi;
                default:  ecc_out = code_mid;
            endcase
        end
    end

endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
    import nand_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_in,
    input  logic             xfer_valid,
    input  logic [BYTE_W-1:0] xfer_data,
    input  logic             rd_strobe,
    output logic             ecc_show,
    output logic [BYTE_W-1:0] ecc_out
);

    ecc_mode_e         mode_q;
    seq_e              seq_q;
    logic [LP_W-1:0]   line_par;
    logic [CP_W-1:0]   col_par;

    ecc_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_in   (mode_in),
        .rd_strobe (rd_strobe),
        .mode_q    (mode_q),
        .seq_q     (seq_q)
    );

    ecc_parity_acc #(.DW(BYTE_W), .IW(IDX_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (mode_q == MODE_CLEAR),
        .enable     (mode_q == MODE_ACCUM),
        .xfer_valid (xfer_valid),
        .xfer_data  (xfer_data),
        .line_par   (line_par),
        .col_par    (col_par)
    );

    assign ecc_show = (mode_q == MODE_SHOW);

    ecc_readout #(.DW(BYTE_W), .LW(LP_W), .CW(CP_W)) u_out (
        .show     (ecc_show),
        .seq      (seq_q),
        .line_par (line_par),
        .col_par  (col_par),
        .ecc_out  (ecc_out)
    );

    AST_DARK_OUTSIDE_SHOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_show |-> ecc_out == '0); // R8

endmodule

// File: tb/tb_nand_ecc_gen.sv
module tb_nand_ecc_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [1:0] mode_in = 2'b00;
    logic       xfer_valid = 1'b0;
    logic [7:0] xfer_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic       ecc_show;
    logic [7:0] ecc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] bufm [0:511];
    int         nbytes = 0;

    always #2 clk = ~clk;

    nand_ecc_gen dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .xfer_valid(xfer_valid), .xfer_data(xfer_data), .rd_strobe(rd_strobe),
        .ecc_show(ecc_show), .ecc_out(ecc_out)
    );

    // reference code {byte2, byte1, byte0} per R5
    function automatic logic [23:0] ref_code(int n);
        logic [15:0] lp = '0;
        logic [5:0]  cp = '0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = bufm[i];
            logic [7:0] ix = i[7:0];
            if (^d) begin
                for (int k = 0; k < 8; k++) begin
                    if (ix[k]) lp[2*k+1] = ~lp[2*k+1];
                    else       lp[2*k]   = ~lp[2*k];
                end
            end
            for (int b = 0; b < 8; b++) begin
                if (d[b]) begin
                    for (int j = 0; j < 3; j++) begin
                        if ((b >> j) & 1) cp[2*j+1] = ~cp[2*j+1];
                        else              cp[2*j]   = ~cp[2*j];
                    end
                end
            end
        end
        return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic xfer(logic [7:0] d, bit record);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_data = d;
        if (record) begin
            bufm[nbytes] = d;
            nbytes++;
        end
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic rd_one(string tag, logic [7:0] exp);
        @(negedge clk);
        chk(tag, ecc_out, exp);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic read3(string tag, logic [23:0] code);
        rd_one({tag, " R6 byte1"}, code[15:8]);
        rd_one({tag, " R6 byte0"}, code[7:0]);
        rd_one({tag, " R6 byte2"}, code[23:16]);
    endtask

    task automatic start_chunk;
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
        nbytes = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] code;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 ecc_show", {7'd0, ecc_show}, 8'h00);
        chk("R1 ecc_out", ecc_out, 8'h00);
        set_mode(2'b10);
        read3("R1 cleared", 24'hFFFFFF);

        // R5 erased chunk
        start_chunk();
        for (int i = 0; i < 256; i++) xfer(8'hFF, 1);
        set_mode(2'b10);
        read3("R5 erased", 24'hFFFFFF);

        // R3 random chunks, several lengths (incl. past 256 for wrap)
        for (int t = 0; t < 6; t++) begin
            int n;
            n = (t == 0) ? 256 : (t == 1) ? 300 : (t == 2) ? 1 : int'($urandom % 280) + 1;
            start_chunk();
            for (int i = 0; i < n; i++) xfer(8'($urandom), 1);
            code = ref_code(nbytes);
            set_mode(2'b10);
            read3("R3 random", code);
            @(negedge clk);
            chk("R6 wrap to byte1", ecc_out, code[15:8]);
        end

        // single-bit directed patterns
        start_chunk();
        xfer(8'h00, 1); xfer(8'h01, 1); xfer(8'h80, 1);
        code = ref_code(nbytes);
        set_mode(2'b10);
        read3("R5 directed", code);

        // R8/R4/R9 idle ignores transfers, code retained
        set_mode(2'b00);
        @(negedge clk);
        chk("R8 idle show", {7'd0, ecc_show}, 8'h00);
        chk("R8 idle out", ecc_out, 8'h00);
        for (int i = 0; i < 5; i++) xfer(8'($urandom), 0);
        set_mode(2'b10);
        @(negedge clk);
        chk("R8 show flag", {7'd0, ecc_show}, 8'h01);
        read3("R4 R9 idle xfers", code);

        // R4 transfers in read-out mode ignored
        for (int i = 0; i < 4; i++) xfer(8'($urandom), 0);
        set_mode(2'b10);
        read3("R4 show xfers", code);

        // R7 restart mid-sequence
        rd_one("R7 first", code[15:8]);
        set_mode(2'b10);
        @(negedge clk);
        chk("R7 restart", ecc_out, code[15:8]);
        // R7 mode write wins over simultaneous strobe
        rd_one("R7 step", code[15:8]);
        @(negedge clk);
        mode_wr = 1'b1; mode_in = 2'b10; rd_strobe = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0; rd_strobe = 1'b0;
        chk("R7 priority", ecc_out, code[15:8]);

        // R2 clear then read gives erased code; accumulate from index 0
        set_mode(2'b11);
        @(negedge clk);
        chk("R2 clear out", ecc_out, 8'h00);
        set_mode(2'b00);
        set_mode(2'b10);
        read3("R2 cleared", 24'hFFFFFF);
        start_chunk();
        for (int i = 0; i < 40; i++) xfer(8'($urandom), 1);
        set_mode(2'b10);
        read3("R2 R3 restart index", ref_code(nbytes));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule